// File: doc/BRIEF.md
# Page-Mode DRAM Strobe Cycle Decoder

This block is a synthesizable stand-in for the memory side of an asynchronous page-mode DRAM. It serves as a bench companion when a memory controller is being verified. A fast sampling clock registers the active-low row strobe, column strobe, write enable and output enable. The block compares each sample with the one before it to find edges. From the order of those edges it works out which kind of access the controller performed.

The block holds a small array of 4-bit words, addressed by the row latched at the row-strobe fall and the column latched at the column-strobe fall. It drives a split data bus, `dq_out` qualified by `dq_oe`, when a read has produced data. It also keeps an internal row counter for refreshes in which the column strobe leads. Every classified access is reported as a one-sample pulse with an encoded kind, so that a scoreboard can follow the controller's traffic.

All reactions are registered. A strobe level presented before sampling edge N is acted on at edge N, and `dq_oe`, `dq_out`, `cyc_valid`, `cyc_kind` and `refresh_row` show the result after that edge. The strobes set the pace of every access, so the pins carry no valid/ready handshake and there is no back-pressure.

Top module: `fpm_strobe_decoder`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it rises, `dq_oe` and `cyc_valid` are 0 and `refresh_row` is 0. Reset also ends any read in progress.
- R2: A column-strobe fall with write enable high, during a normal row-strobe-low period, latches `addr` as the column and reports kind 1 (read). The addressed word then appears on `dq_out` with `dq_oe`=1 for every sample in which both the column strobe and output enable are low.
- R3: A column-strobe fall with write enable already low stores `dq_in` at the latched row and the current `addr`, and reports kind 2 (early write). `dq_oe` stays 0 for the whole access.
- R4: Write enable falling while the column strobe is low, when output enable has stayed high since that column-strobe fall, stores `dq_in` at the latched row and column and reports kind 3 (late write).
- R5: Write enable falling while the column strobe is low, after read data has been driven (output enable was low), stores `dq_in` and reports kind 4 (read-modify-write). The bus is released from the next sample on.
- R6: A row-strobe-low period that began with the column strobe high and saw no column-strobe fall reports kind 5 (row-only refresh) at the row-strobe rise. It drives no data.
- R7: A row-strobe fall while the column strobe is low, with no read data held, reports kind 6 (column-first refresh) and increments `refresh_row`. `addr` is ignored and `dq_oe` stays 0.
- R8: A row-strobe fall while the column strobe is still low from a read whose data is held reports kind 7 (hidden refresh) and increments `refresh_row`. The read data stays on `dq_out` until the column strobe rises.
- R9: During a read, output enable high releases the bus (`dq_oe`=0). Output enable low again, with the column strobe still low, drives the same word again.
- R10: With the column strobe high, `dq_oe` is 0. Each report holds `cyc_valid`=1 for exactly one sample, and `cyc_kind` is nonzero whenever `cyc_valid` is 1.
- R11: Within one row-strobe-low period, successive column-strobe cycles each latch a new column against the same row. Words in different rows with the same column stay separate.
- R12: `refresh_row` is `ADDR_W` bits wide and wraps from its maximum to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DATA_W | Write data |
| dq_out | output | DATA_W | Read data, meaningful while dq_oe is 1 |
| dq_oe | output | 1 | Data bus drive enable |
| cyc_valid | output | 1 | One-sample pulse marking a classified access |
| cyc_kind | output | 3 | Access kind code (1..7, see requirements) |
| refresh_row | output | ADDR_W | Internal refresh row counter |

## Verification
The hardest case to reach is hidden refresh. A read must first latch data with output enable low. The row strobe must then rise and fall again while the column strobe never leaves the low level. Only that sequence separates kind 7 from kind 6 and shows that the held word survives the refresh. The stimulus table builds this sequence one sample at a time and checks the bus at every step. It also sets up plain column-first refreshes, a late write and a read-modify-write in the same page, so that the two write kinds are told apart only by the output-enable history.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    CYC_NONE     = 3'd0,
    CYC_READ     = 3'd1,
    CYC_EARLY_WR = 3'd2,
    CYC_LATE_WR  = 3'd3,
    CYC_RMW      = 3'd4,
    CYC_RAS_ONLY = 3'd5,
    CYC_CBR      = 3'd6,
    CYC_HIDDEN   = 3'd7
  } cyc_kind_e;
endpackage

// File: rtl/fpm_strobe_sampler.sv
module fpm_strobe_sampler #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] lvl_q
);
  // Idle level of every strobe is high.
  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '1;
    else        lvl_q <= lvl;
  end
endmodule

// File: rtl/fpm_cell_array.sv
module fpm_cell_array #(
  parameter int AW = 6,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/fpm_refresh_ctr.sv
module fpm_refresh_ctr #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] row
);
  always_ff @(posedge clk) begin
    if (!rst_n)    row <= '0;
    else if (step) row <= row + 1'b1;
  end
endmodule

// File: rtl/fpm_strobe_decoder.sv
module fpm_strobe_decoder
  import fpm_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              cyc_valid,
  output logic [2:0]        cyc_kind,
  output logic [ADDR_W-1:0] refresh_row
);
  localparam int CELL_AW = 2 * ADDR_W;

  // previous sampled strobe levels
  logic [2:0] strobe_q;
  logic ras_q, cas_q, we_q;

  fpm_strobe_sampler #(.N(3)) u_sampler (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   ({ras_n, cas_n, we_n}),
    .lvl_q (strobe_q)
  );
  assign {ras_q, cas_q, we_q} = strobe_q;

  // per-access state
  logic [ADDR_W-1:0] row_q, col_q;
  logic cbr_q;      // current row-low period is a refresh
  logic seen_q;     // a column access occurred in this row-low period
  logic col_ok_q;   // column latched in this column-low period
  logic wrote_q;    // write already done in this column-low period
  logic valid_q;    // read data held
  logic shown_q;    // held data was driven at least once
  logic [DATA_W-1:0] dout_q;
  logic oe_drv_q;
  logic rep_q;
  cyc_kind_e kind_q;

  // edges
  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  assign ras_fall = ras_q & ~ras_n;
  assign ras_rise = ~ras_q & ras_n;
  assign cas_fall = cas_q & ~cas_n;
  assign cas_rise = ~cas_q & cas_n;
  assign we_fall  = we_q & ~we_n;

  // events
  logic cbr_ev, acc, rd_ev, ew_ev, wr_late, ro_ev, any_ev, valid_nxt;
  cyc_kind_e kind_nxt;

  assign cbr_ev  = ras_fall & ~cas_n;
  assign acc     = ~ras_n & ~cbr_q & ~cbr_ev;
  assign rd_ev   = cas_fall & acc & we_n;
  assign ew_ev   = cas_fall & acc & ~we_n;
  assign wr_late = we_fall & ~cas_n & ~cas_fall & acc & col_ok_q & ~wrote_q;
  assign ro_ev   = ras_rise & ~cbr_q & ~seen_q;
  assign any_ev  = cbr_ev | rd_ev | ew_ev | wr_late | ro_ev;

  always_comb begin
    if (rd_ev)                   valid_nxt = 1'b1;
    else if (cas_rise | wr_late) valid_nxt = 1'b0;
    else                         valid_nxt = valid_q;
  end

  always_comb begin
    kind_nxt = CYC_NONE;
    if (cbr_ev)       kind_nxt = valid_q ? CYC_HIDDEN : CYC_CBR;
    else if (rd_ev)   kind_nxt = CYC_READ;
    else if (ew_ev)   kind_nxt = CYC_EARLY_WR;
    else if (wr_late) kind_nxt = shown_q ? CYC_RMW : CYC_LATE_WR;
    else if (ro_ev)   kind_nxt = CYC_RAS_ONLY;
  end

  // storage
  logic [DATA_W-1:0]  rd_word;
  logic [CELL_AW-1:0] wr_cell;
  assign wr_cell = ew_ev ? {row_q, addr} : {row_q, col_q};

  fpm_cell_array #(.AW(CELL_AW), .DW(DATA_W)) u_cells (
    .clk     (clk),
    .wr_en   (ew_ev | wr_late),
    .wr_addr (wr_cell),
    .wr_data (dq_in),
    .rd_addr ({row_q, addr}),
    .rd_data (rd_word)
  );

  fpm_refresh_ctr #(.W(ADDR_W)) u_refresh (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (cbr_ev),
    .row   (refresh_row)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q    <= '0;
      col_q    <= '0;
      cbr_q    <= 1'b0;
      seen_q   <= 1'b0;
      col_ok_q <= 1'b0;
      wrote_q  <= 1'b0;
      valid_q  <= 1'b0;
      shown_q  <= 1'b0;
      dout_q   <= '0;
      oe_drv_q <= 1'b0;
      rep_q    <= 1'b0;
      kind_q   <= CYC_NONE;
    end else begin
      if (ras_fall && !cbr_ev) row_q <= addr;
      if (rd_ev | ew_ev)       col_q <= addr;
      if (rd_ev)               dout_q <= rd_word;

      if (cbr_ev)        cbr_q <= 1'b1;
      else if (ras_rise) cbr_q <= 1'b0;

      if (ras_fall)            seen_q <= 1'b0;
      else if (rd_ev | ew_ev)  seen_q <= 1'b1;

      if (rd_ev | ew_ev) col_ok_q <= 1'b1;
      else if (cas_rise) col_ok_q <= 1'b0;

      if (ew_ev | wr_late) wrote_q <= 1'b1;
      else if (cas_rise)   wrote_q <= 1'b0;

      if (cas_rise | rd_ev)          shown_q <= 1'b0;
      else if (valid_nxt && !oe_n)   shown_q <= 1'b1;
      if (rd_ev && !oe_n)            shown_q <= 1'b1;

      valid_q  <= valid_nxt;
      oe_drv_q <= valid_nxt & ~cas_n & ~oe_n;
      rep_q    <= any_ev;
      kind_q   <= kind_nxt;
    end
  end

  assign dq_out    = dout_q;
  assign dq_oe     = oe_drv_q;
  assign cyc_valid = rep_q;
  assign cyc_kind  = kind_q;
endmodule

// File: rtl/fpm_decoder_chk.sv
module fpm_decoder_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cas_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic              cyc_valid,
  input logic [2:0]        cyc_kind,
  input logic [ADDR_W-1:0] refresh_row
);
  AST_DRIVE_NEEDS_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(!cas_n && !oe_n)); // R9

  AST_CAS_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cas_n) |-> !dq_oe); // R10

  AST_KIND_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> cyc_kind != 3'd0); // R10

  AST_REFRESH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_row != $past(refresh_row)) |-> (cyc_valid && (cyc_kind == 3'd6 || cyc_kind == 3'd7))); // R7

  AST_EARLY_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_kind == 3'd2) |-> !dq_oe); // R3

  AST_CBR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_kind == 3'd6) |-> !dq_oe); // R7

  AST_WRITE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && (cyc_kind == 3'd3 || cyc_kind == 3'd4)) |-> !dq_oe); // R5
endmodule

bind fpm_strobe_decoder fpm_decoder_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cas_n       (cas_n),
  .oe_n        (oe_n),
  .dq_oe       (dq_oe),
  .cyc_valid   (cyc_valid),
  .cyc_kind    (cyc_kind),
  .refresh_row (refresh_row)
);

// File: tb/fpm_strobe_decoder_tb_top.sv
module fpm_strobe_decoder_tb_top;
  localparam int AW = 3;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe, cyc_valid;
  logic [2:0] cyc_kind;
  logic [AW-1:0] refresh_row;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  fpm_strobe_decoder #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .cyc_valid(cyc_valid), .cyc_kind(cyc_kind), .refresh_row(refresh_row)
  );

  typedef struct packed {
    logic [23:0]   tag;
    logic          ras, cas, we, oe;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          ev;
    logic [2:0]    kind;
    logic          drv;
    logic [DW-1:0] dout;
  } vec_t;

  // ras cas we oe addr din | report kind drive data
  localparam int NV = 38;
  localparam vec_t VEC [NV] = '{
    '{"R1",  1,1,1,1, 3'd0, 4'h0, 0,3'd0, 0,4'h0},
    '{"R3",  0,1,1,1, 3'd2, 4'h0, 0,3'd0, 0,4'h0},
    '{"R3",  0,1,0,1, 3'd3, 4'hA, 0,3'd0, 0,4'h0},
    '{"R3",  0,0,0,1, 3'd3, 4'hA, 1,3'd2, 0,4'h0},
    '{"R10", 0,1,1,1, 3'd3, 4'h0, 0,3'd0, 0,4'h0},
    '{"R6",  1,1,1,1, 3'd0, 4'h0, 0,3'd0, 0,4'h0},
    '{"R2",  0,1,1,1, 3'd2, 4'h0, 0,3'd0, 0,4'h0},
    '{"R2",  0,0,1,1, 3'd3, 4'h0, 1,3'd1, 0,4'h0},
    '{"R2",  0,0,1,0, 3'd3, 4'h0, 0,3'd0, 1,4'hA},
    '{"R9",  0,0,1,1, 3'd3, 4'h0, 0,3'd0, 0,4'h0},
    '{"R9",  0,0,1,0, 3'd3, 4'h0, 0,3'd0, 1,4'hA},
    '{"R10", 0,1,1,0, 3'd3, 4'h0, 0,3'd0, 0,4'h0},
    '{"R11", 0,0,1,1, 3'd5, 4'h0, 1,3'd1, 0,4'h0},
    '{"R4",  0,0,0,1, 3'd5, 4'h5, 1,3'd3, 0,4'h0},
    '{"R4",  0,1,1,1, 3'd5, 4'h0, 0,3'd0, 0,4'h0},
    '{"R11", 0,0,1,1, 3'd5, 4'h0, 1,3'd1, 0,4'h0},
    '{"R4",  0,0,1,0, 3'd5, 4'h0, 0,3'd0, 1,4'h5},
    '{"R9",  0,0,1,1, 3'd5, 4'h0, 0,3'd0, 0,4'h0},
    '{"R5",  0,0,0,1, 3'd5, 4'hC, 1,3'd4, 0,4'h0},
    '{"R5",  0,1,1,1, 3'd5, 4'h0, 0,3'd0, 0,4'h0},
    '{"R6",  1,1,1,1, 3'd0, 4'h0, 0,3'd0, 0,4'h0},
    '{"R2",  0,1,1,1, 3'd2, 4'h0, 0,3'd0, 0,4'h0},
    '{"R5",  0,0,1,0, 3'd5, 4'h0, 1,3'd1, 1,4'hC},
    '{"R8",  1,0,1,0, 3'd5, 4'h0, 0,3'd0, 1,4'hC},
    '{"R8",  0,0,1,0, 3'd7, 4'h0, 1,3'd7, 1,4'hC},
    '{"R8",  1,0,1,0, 3'd7, 4'h0, 0,3'd0, 1,4'hC},
    '{"R10", 1,1,1,0, 3'd0, 4'h0, 0,3'd0, 0,4'h0},
    '{"R7",  1,0,1,0, 3'd0, 4'h0, 0,3'd0, 0,4'h0},
    '{"R7",  0,0,1,0, 3'd6, 4'h0, 1,3'd6, 0,4'h0},
    '{"R7",  1,1,1,1, 3'd0, 4'h0, 0,3'd0, 0,4'h0},
    '{"R6",  0,1,1,1, 3'd1, 4'h0, 0,3'd0, 0,4'h0},
    '{"R6",  1,1,1,1, 3'd1, 4'h0, 1,3'd5, 0,4'h0},
    '{"R11", 0,1,1,1, 3'd4, 4'h0, 0,3'd0, 0,4'h0},
    '{"R11", 0,0,0,1, 3'd3, 4'h9, 1,3'd2, 0,4'h0},
    '{"R11", 1,1,1,1, 3'd0, 4'h0, 0,3'd0, 0,4'h0},
    '{"R11", 0,1,1,1, 3'd2, 4'h0, 0,3'd0, 0,4'h0},
    '{"R11", 0,0,1,0, 3'd3, 4'h0, 1,3'd1, 1,4'hA},
    '{"R10", 1,1,1,1, 3'd0, 4'h0, 0,3'd0, 0,4'h0}
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic column_first_refresh();
    cas_n = 1'b0; @(negedge clk);
    ras_n = 1'b0; @(negedge clk);
    ras_n = 1'b1; cas_n = 1'b1; @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs during reset
    chk("R1", "dq_oe in reset", int'(dq_oe), 0);
    chk("R1", "cyc_valid in reset", int'(cyc_valid), 0);
    chk("R1", "refresh_row in reset", int'(refresh_row), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      ras_n = VEC[i].ras; cas_n = VEC[i].cas;
      we_n  = VEC[i].we;  oe_n  = VEC[i].oe;
      addr  = VEC[i].a;   dq_in = VEC[i].d;
      @(negedge clk);
      chk(string'(VEC[i].tag), $sformatf("step %0d cyc_valid", i), int'(cyc_valid), int'(VEC[i].ev));
      if (VEC[i].ev)
        chk(string'(VEC[i].tag), $sformatf("step %0d cyc_kind", i), int'(cyc_kind), int'(VEC[i].kind));
      chk(string'(VEC[i].tag), $sformatf("step %0d dq_oe", i), int'(dq_oe), int'(VEC[i].drv));
      if (VEC[i].drv)
        chk(string'(VEC[i].tag), $sformatf("step %0d dq_out", i), int'(dq_out), int'(VEC[i].dout));
    end

    // R7 / R8: one hidden and one column-first refresh so far
    chk("R8", "refresh_row after refreshes", int'(refresh_row), 2);

    // R12: six more refreshes wrap the 3-bit counter to 0
    column_first_refresh();
    chk("R7", "refresh_row step", int'(refresh_row), 3);
    for (int k = 0; k < 5; k++) column_first_refresh();
    chk("R12", "refresh_row wrap", int'(refresh_row), 0);

    // R1: reset in the middle of a driven read
    column_first_refresh();
    ras_n = 1'b0; addr = 3'd2; @(negedge clk);
    cas_n = 1'b0; oe_n = 1'b0; addr = 3'd3; @(negedge clk);
    chk("R2", "read before reset drives", int'(dq_oe), 1);
    chk("R2", "read before reset data", int'(dq_out), 4'hA);
    rst_n = 1'b0; @(negedge clk);
    chk("R1", "dq_oe after reset", int'(dq_oe), 0);
    chk("R1", "refresh_row after reset", int'(refresh_row), 0);
    ras_n = 1'b1; cas_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1; @(negedge clk);
    chk("R1", "cyc_valid after release", int'(cyc_valid), 0);
    chk("R1", "dq_oe after release", int'(dq_oe), 0);

    finish_run();
  end
endmodule